// File: doc/BRIEF.md
# Gain-Step Serial Word Programmer

This block sits on the host side of a three-wire control port (serial clock, serial data, load strobe). It belongs to a front-end receiver whose gain and power settings live in a 24-bit operating register. A request comes in over a valid/ready handshake. It carries an LNA mode, the power, standby, bypass and DC-correction control bits of each section, and two 4-bit gain step indices. The block turns each step index into a 6-bit code made of two 3-bit thermometer halves. It builds the control word and shifts it out least significant bit first. It then pulses the strobe so the receiving side loads the word.

All serial timing is counted in system-clock cycles and set by parameters: the serial clock half period, the guard time around the strobe, and the strobe width. At a 250 MHz system clock, a value of 5 gives the 20 ns minimum that the port needs for clock high time, clock low time, data setup and hold, and strobe setup and hold. A request that asks for the forbidden LNA setting is refused. The block flags it and sends nothing.

The handshake has no queue. `req_ready` equals `!busy`, so a request held valid while a word is in flight waits and is not taken. A request presented during the `done` cycle is accepted in that same cycle. There is no other back-pressure.

Top module: `gain_word_prog`

## Requirements
- R1: `req_ready` is high exactly when `busy` is low. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Field values presented while `busy` is high have no effect on the word in flight.
- R2: An accepted word produces exactly 24 rising edges of `ser_clk`. The bit at position 0 goes out first and position 23 goes out last.
- R3: Word layout:
  - bit0 = `req_lna[0]` (LNA power) and bit1 = `req_lna[1]` (LNA gain select);
  - bit2 = RF mixer standby, bit3 = RF mixer power, bit4 = IF mixer power, bit5 = IF mixer bypass;
  - bits 11:6 = first gain code and bits 19:14 = second gain code, each with code bit 0 at the lower position;
  - bit12 = demodulator power, bit13 = demodulator standby;
  - bit20 = DC-correction disable;
  - bits 23:21 = 0.
- R4: A step index k (0..15) becomes the code {T(k/4), T(k mod 4)}, where T(0)=000, T(1)=001, T(2)=011 and T(3)=111. The upper thermometer occupies code bits 5:3.
- R5: A request taken with `req_lna` = 2'b11 gives a one-cycle `reject` pulse in the next cycle. It starts no transfer: `busy` and all serial outputs stay low.
- R6: After acceptance, each bit is held for HALF_CYC cycles with `ser_clk` low and then HALF_CYC cycles with `ser_clk` high. `ser_dat` changes only while `ser_clk` is low, at the falling edge of the clock or at acceptance.
- R7: After the last falling edge, `ser_dat` is 0. There follow GUARD_CYC cycles with strobe low, then STB_CYC cycles with `ser_stb` high, then GUARD_CYC more busy cycles. `ser_clk` stays low throughout.
- R8: `done` is high for one cycle, with `busy` low, immediately after the final guard period.
- R9: After reset, all outputs are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken (idle) |
| req_lna | input | 2 | LNA mode: 00 off, 01 high gain, 10 low gain, 11 forbidden |
| req_rfmix_stby | input | 1 | RF mixer standby bit |
| req_rfmix_pwr | input | 1 | RF mixer power bit |
| req_ifmix_pwr | input | 1 | IF mixer power bit |
| req_ifmix_byp | input | 1 | IF mixer bypass bit |
| req_dem_pwr | input | 1 | Demodulator power bit |
| req_dem_stby | input | 1 | Demodulator standby bit |
| req_dc_off | input | 1 | DC-correction disable bit |
| req_gain1 | input | 4 | First gain step index |
| req_gain2 | input | 4 | Second gain step index |
| ser_clk | output | 1 | Serial clock |
| ser_dat | output | 1 | Serial data |
| ser_stb | output | 1 | Load strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| reject | output | 1 | One-cycle pulse for a refused request |

## Verification
Two events can fall in the same cycle: the `done` pulse that ends one word, and the acceptance of the next request. Because `req_ready` rises together with `done`, a request held valid through the tail of a transfer is taken in that cycle. The bench provokes this by raising `req_valid` with a second word while the first is still busy. It then judges, cycle by cycle against its reference timeline, that the next low phase begins right after the `done` cycle and that both shifted words decode correctly. A refused LNA request arriving at that same boundary is also exercised, and is expected to give `reject` with no serial activity.

// File: rtl/gwp_pkg.sv
package gwp_pkg;
  localparam int WORD_W = 24;
  localparam int STEP_W = 4;
  localparam int CODE_W = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_PRE,
    ST_STB,
    ST_POST
  } eng_state_t;

  // 2-bit count to 3-bit thermometer
  function automatic logic [2:0] therm3(input logic [1:0] n);
    logic [2:0] t;
    for (int i = 0; i < 3; i++) t[i] = (i < int'(n));
    return t;
  endfunction
endpackage

// File: rtl/gwp_gain_enc.sv
module gwp_gain_enc
  import gwp_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  output logic [CODE_W-1:0] code
);
  // coarse part (step/4) in upper half, fine part (step mod 4) in lower half
  always_comb begin
    code = {therm3(step[3:2]), therm3(step[1:0])};
  end
endmodule

// File: rtl/gwp_word_build.sv
module gwp_word_build
  import gwp_pkg::*;
(
  input  logic [1:0]        lna,
  input  logic              rfmix_stby,
  input  logic              rfmix_pwr,
  input  logic              ifmix_pwr,
  input  logic              ifmix_byp,
  input  logic              dem_pwr,
  input  logic              dem_stby,
  input  logic              dc_off,
  input  logic [CODE_W-1:0] code1,
  input  logic [CODE_W-1:0] code2,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word        = '0;
    word[1:0]   = lna;
    word[2]     = rfmix_stby;
    word[3]     = rfmix_pwr;
    word[4]     = ifmix_pwr;
    word[5]     = ifmix_byp;
    word[11:6]  = code1;
    word[12]    = dem_pwr;
    word[13]    = dem_stby;
    word[19:14] = code2;
    word[20]    = dc_off;
  end
endmodule

// File: rtl/gwp_ser_engine.sv
module gwp_ser_engine
  import gwp_pkg::*;
#(
  parameter int HALF_CYC  = 5,
  parameter int GUARD_CYC = 5,
  parameter int STB_CYC   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              ser_stb,
  output logic              busy,
  output logic              done
);
  localparam int MAXC  = (HALF_CYC > GUARD_CYC) ?
                         ((HALF_CYC > STB_CYC) ? HALF_CYC : STB_CYC) :
                         ((GUARD_CYC > STB_CYC) ? GUARD_CYC : STB_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] H_LAST = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] G_LAST = CNT_W'(GUARD_CYC - 1);
  localparam logic [CNT_W-1:0] S_LAST = CNT_W'(STB_CYC - 1);
  localparam logic [IDX_W-1:0] I_LAST = IDX_W'(WORD_W - 1);

  eng_state_t        st;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] sh;

  assign ser_dat = sh[0];
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      ser_clk <= 1'b0;
      ser_stb <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (load) begin
            st      <= ST_SHIFT;
            sh      <= word;
            cnt     <= '0;
            idx     <= '0;
            ser_clk <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (cnt == H_LAST) begin
            cnt <= '0;
            if (!ser_clk) begin
              ser_clk <= 1'b1;
            end else begin
              ser_clk <= 1'b0;
              sh      <= {1'b0, sh[WORD_W-1:1]};
              if (idx == I_LAST) st <= ST_PRE;
              else               idx <= idx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PRE: begin
          if (cnt == G_LAST) begin
            cnt     <= '0;
            st      <= ST_STB;
            ser_stb <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_STB: begin
          if (cnt == S_LAST) begin
            cnt     <= '0;
            st      <= ST_POST;
            ser_stb <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        ST_POST: begin
          if (cnt == G_LAST) begin
            cnt  <= '0;
            st   <= ST_IDLE;
            done <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6: data moves only while the serial clock is low
  assert_dat_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_dat) |-> !ser_clk);
  // R7: strobe only with the clock idle low and inside a transfer
  assert_stb_clk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_stb |-> (!ser_clk && busy));
  // R8: done lasts one cycle and comes with busy low
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done));
  // R9: port quiet when idle
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_stb));
endmodule

// File: rtl/gain_word_prog.sv
module gain_word_prog
  import gwp_pkg::*;
#(
  parameter int HALF_CYC  = 5,
  parameter int GUARD_CYC = 5,
  parameter int STB_CYC   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_lna,
  input  logic       req_rfmix_stby,
  input  logic       req_rfmix_pwr,
  input  logic       req_ifmix_pwr,
  input  logic       req_ifmix_byp,
  input  logic       req_dem_pwr,
  input  logic       req_dem_stby,
  input  logic       req_dc_off,
  input  logic [3:0] req_gain1,
  input  logic [3:0] req_gain2,
  output logic       ser_clk,
  output logic       ser_dat,
  output logic       ser_stb,
  output logic       busy,
  output logic       done,
  output logic       reject
);
  localparam int NCH = 2;

  logic [NCH-1:0][STEP_W-1:0] steps;
  logic [NCH-1:0][CODE_W-1:0] codes;
  logic [WORD_W-1:0]          word;
  logic                       take, bad_lna;

  assign steps = {req_gain2, req_gain1};

  for (genvar c = 0; c < NCH; c++) begin : g_enc
    gwp_gain_enc u_enc (.step(steps[c]), .code(codes[c]));
  end

  gwp_word_build u_build (
    .lna(req_lna), .rfmix_stby(req_rfmix_stby), .rfmix_pwr(req_rfmix_pwr),
    .ifmix_pwr(req_ifmix_pwr), .ifmix_byp(req_ifmix_byp),
    .dem_pwr(req_dem_pwr), .dem_stby(req_dem_stby), .dc_off(req_dc_off),
    .code1(codes[0]), .code2(codes[1]), .word(word)
  );

  assign req_ready = !busy;
  assign take      = req_valid && req_ready;
  assign bad_lna   = (req_lna == 2'b11);

  gwp_ser_engine #(.HALF_CYC(HALF_CYC), .GUARD_CYC(GUARD_CYC), .STB_CYC(STB_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .load(take && !bad_lna), .word(word),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_stb(ser_stb),
    .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reject <= 1'b0;
    else        reject <= take && bad_lna;
  end

  // R5: a refused request never starts a transfer
  assert_reject_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !busy);
  // R5: a transfer never starts from the forbidden LNA pair
  assert_no_bad_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(req_lna) != 2'b11));
  // R1: a transfer starts only from a valid request
  assert_start_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
endmodule

// File: tb/gain_word_prog_test.sv
module gain_word_prog_test;
  localparam int H = 5, G = 5, S = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_lna = 0;
  logic rfs = 0, rfp = 0, ifp = 0, ifb = 0, dmp = 0, dms = 0, dco = 0;
  logic [3:0] g1 = 0, g2 = 0;
  logic ser_clk, ser_dat, ser_stb, busy, done, reject;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  gain_word_prog #(.HALF_CYC(H), .GUARD_CYC(G), .STB_CYC(S)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lna(req_lna), .req_rfmix_stby(rfs), .req_rfmix_pwr(rfp),
    .req_ifmix_pwr(ifp), .req_ifmix_byp(ifb), .req_dem_pwr(dmp),
    .req_dem_stby(dms), .req_dc_off(dco), .req_gain1(g1), .req_gain2(g2),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_stb(ser_stb),
    .busy(busy), .done(done), .reject(reject)
  );

  function automatic logic [5:0] tcode(input int k);
    logic [5:0] c = '0;
    for (int i = 0; i < k / 4; i++) c[3 + i] = 1'b1;
    for (int i = 0; i < k % 4; i++) c[i] = 1'b1;
    return c;
  endfunction

  function automatic logic [23:0] exp_word();
    logic [23:0] w = '0;
    w[0] = req_lna[0]; w[1] = req_lna[1];
    w[2] = rfs; w[3] = rfp; w[4] = ifp; w[5] = ifb;
    w[11:6] = tcode(int'(g1));
    w[12] = dmp; w[13] = dms;
    w[19:14] = tcode(int'(g2));
    w[20] = dco;
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference timeline: entry bits {rej,done,busy,stb,dat,clk}
  logic [5:0]  tl[$];
  logic [23:0] words[$];
  logic [5:0]  cur = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      tl.delete(); cur = '0;
    end else begin
      logic acc, bad;
      logic [5:0] nxt;
      acc = req_valid && !cur[3];
      bad = (req_lna == 2'b11);
      if (acc && !bad) begin
        logic [23:0] w;
        w = exp_word();
        words.push_back(w);
        for (int b = 0; b < 24; b++) begin
          for (int i = 0; i < H; i++) tl.push_back({4'b0010, w[b], 1'b0});
          for (int i = 0; i < H; i++) tl.push_back({4'b0010, w[b], 1'b1});
        end
        for (int i = 0; i < G; i++) tl.push_back(6'b001000);
        for (int i = 0; i < S; i++) tl.push_back(6'b001100);
        for (int i = 0; i < G; i++) tl.push_back(6'b001000);
        tl.push_back(6'b010000);
      end
      nxt = (tl.size() > 0) ? tl.pop_front() : 6'b0;
      if (acc && bad) nxt[5] = 1'b1;
      cur = nxt;
    end
  end

  // decoded word captured at the serial port
  logic [23:0] cap = '0;
  int          nedge = 0;
  always @(posedge ser_clk) begin
    cap = {ser_dat, cap[23:1]};
    nedge++;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R6 ser_clk", ser_clk, cur[0]);
      check("R2/R3 ser_dat", ser_dat, cur[1]);
      check("R7 ser_stb", ser_stb, cur[2]);
      check("R1 busy", busy, cur[3]);
      check("R1 req_ready", req_ready, !cur[3]);
      check("R8 done", done, cur[4]);
      check("R5 reject", reject, cur[5]);
      if (cur[4]) begin
        logic [23:0] ew;
        ew = (words.size() > 0) ? words.pop_front() : 24'hx;
        check("R2 edge count", nedge, 24);
        check("R3/R4 word", cap, ew);
        nedge = 0;
      end
    end
  end

  task automatic set_req(input logic [1:0] l, input logic [6:0] f, input int a, input int b);
    req_lna = l;
    {rfs, rfp, ifp, ifb, dmp, dms, dco} = f;
    g1 = a[3:0]; g2 = b[3:0];
  endtask

  task automatic send(input logic [1:0] l, input logic [6:0] f, input int a, input int b);
    @(negedge clk);
    set_req(l, f, a, b);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset ser_clk", ser_clk, 0);
    check("R9 reset ser_stb", ser_stb, 0);
    check("R9 reset busy", busy, 0);
    check("R9 reset ready", req_ready, 1);
    check("R9 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3/R4: field and gain patterns
    send(2'b01, 7'b1010101, 0, 15);  wait_idle();
    send(2'b10, 7'b0101010, 5, 10);  wait_idle();
    send(2'b00, 7'b1111111, 12, 3);  wait_idle();
    // R4: every step index on both codes
    for (int k = 0; k < 16; k++) begin
      send(2'b01, 7'b0000000, k, 15 - k); wait_idle();
    end
    // R5: forbidden LNA pair refused, no transfer
    send(2'b11, 7'b1111111, 7, 7);
    repeat (20) @(negedge clk);
    // R1: request while busy is ignored
    send(2'b10, 7'b0011001, 9, 2);
    repeat (30) @(negedge clk);
    set_req(2'b01, 7'b1100110, 14, 1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    set_req(2'b00, 7'b0000000, 0, 0);
    wait_idle();
    // R8: next request held valid, taken in the done cycle
    send(2'b01, 7'b1000001, 3, 8);
    @(negedge clk);
    set_req(2'b10, 7'b0110110, 11, 6);
    req_valid = 1'b1;
    while (!done) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    // R5 at the done boundary
    send(2'b01, 7'b0000001, 1, 1);
    set_req(2'b11, 7'b0, 0, 0);
    req_valid = 1'b1;
    while (!done) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    check("R5 no pending word", words.size(), 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule